// File: doc/BRIEF.md
# Goertzel Systolic DFT Array

This block computes an N-point discrete Fourier transform on a stream of complex fixed-point samples. It is built as a straight line of identical cells, one for each frequency bin. Samples arrive at the first cell at up to one per clock. Each sample then moves one cell further along a register chain on every clock, so every cell has a new sample on every step. Cell k keeps one complex accumulator. On each sample it multiplies the accumulator by its own constant rotation exp(+j·2πk/N) and adds the sample. After N samples, one more rotation of the total gives bin k in the usual forward-transform sign convention.

Frames of N samples can follow each other with no gap. A frame-start marker travels down the chain with the data. Each cell keeps its own modulo-N sample counter, so cell k works on its frame k cycles after cell 0. Bins therefore leave the array one per cycle, in cell order, on a single output stream that carries the cell index. The rotation constants are computed at elaboration into signed Q1.14 values, with 16384 standing for 1.0. The accumulator has W + ceil(log2 N) + 1 bits, which is 19 bits for the defaults (N = 3, 16-bit samples).

Top module: `goertzel_dft_array`

## Requirements
- R1: While rst_n is low, and on the first cycle after it goes high, bin_valid is 0 and bin_re and bin_im are 0. No bin appears before a frame has completed.
- R2: For a frame x0..x(N-1), the bin with index k equals the sum over n of x(n)·exp(-j·2πkn/N). The real part and the imaginary part are each within 8 LSB of the exact value. This holds for any input within the signed W-bit range.
- R3: Let e be the rising edge that captures the last sample of a frame. The bin with index k is then presented after edge e+k+1, and bin_valid is high for exactly that one cycle.
- R4: bin_idx equals the bin number k (0..N-1) of the bin being presented. At most one bin is presented per cycle.
- R5: With in_valid high on every cycle, back-to-back frames each produce N bins. Each bin depends only on the samples of its own frame: the first sample of a frame reloads the accumulator.
- R6: A cycle with in_valid low neither advances a frame nor changes any accumulator. in_sof, in_re and in_im are ignored on such a cycle. Bins of a frame with gaps are still timed from the edge that captures its last sample.
- R7: A valid sample with in_sof = 1 is sample 0 of a new frame. An unfinished frame is then discarded and produces no bins.
- R8: If in_sof is not used, frames are delimited by counting N valid samples. The count starts from the first valid sample after reset, or from the last frame start.
- R9: On a cycle where bin_valid is 0, bin_idx, bin_re and bin_im are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample on in_re/in_im is valid this cycle |
| in_sof | input | 1 | Valid sample is the first of a frame |
| in_re | input | W | Sample real part, signed |
| in_im | input | W | Sample imaginary part, signed |
| bin_valid | output | 1 | A bin is presented this cycle |
| bin_idx | output | $clog2(N) | Bin number of the presented bin |
| bin_re | output | W+$clog2(N)+1 | Bin real part, signed |
| bin_im | output | W+$clog2(N)+1 | Bin imaginary part, signed |

## Verification
Suppose an accumulator is not reloaded at a frame start. The bins of the very next frame then carry leftover energy, and the value comparison catches this no later than N+1 cycles after that frame's last sample. A phase counter that slips, or a frame marker lost in the skew chain, moves a bin pulse to another cycle, adds one or drops one. Because the bench compares the output stream on every clock, such an error shows as an unexpected or missing pulse within one frame. A cell whose state moves on idle cycles corrupts the values of the frame in which the gap occurred.

// File: rtl/goertzel_dft_pkg.sv
`timescale 1ns/1ps
// Package goertzel_dft_pkg
// Computes the rotation constants for the cells at elaboration time.
// Only basic real arithmetic is used (series expansions), so no math
// library is needed. Results are rounded to signed fixed point.
package goertzel_dft_pkg;

    localparam real TWO_PI = 6.283185307179586;
    localparam real PI     = 3.141592653589793;

    // Fold an angle into [-pi, pi] so the series converges quickly.
    function automatic real fold_angle(real a);
        real r;
        r = a;
        while (r > PI)  r = r - TWO_PI;
        while (r < -PI) r = r + TWO_PI;
        return r;
    endfunction

    // Cosine by Taylor series.
    function automatic real series_cos(real a);
        real x, term, sum;
        x    = fold_angle(a);
        term = 1.0;
        sum  = 1.0;
        for (int i = 1; i < 24; i++) begin
            term = -term * x * x / real'((2 * i - 1) * (2 * i));
            sum  = sum + term;
        end
        return sum;
    endfunction

    // Sine by Taylor series.
    function automatic real series_sin(real a);
        real x, term, sum;
        x    = fold_angle(a);
        term = x;
        sum  = x;
        for (int i = 1; i < 24; i++) begin
            term = -term * x * x / real'((2 * i) * (2 * i + 1));
            sum  = sum + term;
        end
        return sum;
    endfunction

    // Round a real value to an integer with 'frac' fractional bits.
    function automatic int to_fixed(real v, int frac);
        real scale;
        scale = 1.0;
        for (int i = 0; i < frac; i++) scale = scale * 2.0;
        if (v >= 0.0) return $rtoi(v * scale + 0.5);
        return -$rtoi(-v * scale + 0.5);
    endfunction

    // Real part of exp(+j*2*pi*k/n) in fixed point.
    function automatic int rot_re(int k, int n, int frac);
        return to_fixed(series_cos(TWO_PI * real'(k) / real'(n)), frac);
    endfunction

    // Imaginary part of exp(+j*2*pi*k/n) in fixed point.
    function automatic int rot_im(int k, int n, int frac);
        return to_fixed(series_sin(TWO_PI * real'(k) / real'(n)), frac);
    endfunction

endpackage

// File: rtl/dft_cmul.sv
`timescale 1ns/1ps
// Module dft_cmul
// Combinational complex multiply of an accumulator value by a fixed-point
// constant. It uses four real products and two sums, then rounds half up
// back to the accumulator width.
// Assumes: the constant has FRAC fractional bits, and the rounded result
// fits in AW bits (the caller bounds the magnitude).
module dft_cmul #(
    parameter int AW   = 19,
    parameter int CW   = 16,
    parameter int FRAC = 14
) (
    input  logic signed [AW-1:0] a_re,
    input  logic signed [AW-1:0] a_im,
    input  logic signed [CW-1:0] c_re,
    input  logic signed [CW-1:0] c_im,
    output logic signed [AW-1:0] p_re,
    output logic signed [AW-1:0] p_im
);
    localparam int PW = AW + CW + 1;
    localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (FRAC - 1);

    logic signed [PW-1:0] ar, ai, cr, ci;
    logic signed [PW-1:0] sum_re, sum_im;

    // Widen the operands, form the cross products, round and shift down.
    always_comb begin
        ar     = PW'(a_re);
        ai     = PW'(a_im);
        cr     = PW'(c_re);
        ci     = PW'(c_im);
        sum_re = ar * cr - ai * ci + HALF_LSB;
        sum_im = ar * ci + ai * cr + HALF_LSB;
        p_re   = AW'(sum_re >>> FRAC);
        p_im   = AW'(sum_im >>> FRAC);
    end
endmodule

// File: rtl/dft_skew_stage.sv
`timescale 1ns/1ps
// Module dft_skew_stage
// One register of the sample chain between neighbouring cells. It moves
// the valid flag, the frame marker and the data one cell per clock.
// Assumes: the chain advances every clock, whether or not the sample is
// valid.
module dft_skew_stage #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                d_valid,
    input  logic                d_sof,
    input  logic signed [W-1:0] d_re,
    input  logic signed [W-1:0] d_im,
    output logic                q_valid,
    output logic                q_sof,
    output logic signed [W-1:0] q_re,
    output logic signed [W-1:0] q_im
);
    // Pass the sample to the next cell; reset clears the flags and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_sof   <= 1'b0;
            q_re    <= '0;
            q_im    <= '0;
        end else begin
            q_valid <= d_valid;
            q_sof   <= d_valid & d_sof;
            q_re    <= d_re;
            q_im    <= d_im;
        end
    end
endmodule

// File: rtl/dft_cell.sv
`timescale 1ns/1ps
// Module dft_cell
// One cell of the array, holding one frequency bin. On each valid sample
// the accumulator becomes accumulator*rotation + sample. Sample 0 of a
// frame loads the accumulator directly instead. On the clock after
// sample N-1, the cell presents accumulator*rotation as its bin, for one
// cycle.
// Assumes: N >= 2. The incoming frame marker is only meaningful together
// with s_valid.
module dft_cell #(
    parameter  int N    = 3,
    parameter  int W    = 16,
    parameter  int CW   = 16,
    parameter  int AW   = W + $clog2(N) + 1,
    parameter  int K    = 0,
    localparam int CNTW = $clog2(N),
    localparam int FRAC = CW - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic                 s_sof,
    input  logic signed [W-1:0]  s_re,
    input  logic signed [W-1:0]  s_im,
    output logic                 o_valid,
    output logic signed [AW-1:0] o_re,
    output logic signed [AW-1:0] o_im
);
    localparam logic signed [CW-1:0] ROT_RE = CW'(goertzel_dft_pkg::rot_re(K, N, FRAC));
    localparam logic signed [CW-1:0] ROT_IM = CW'(goertzel_dft_pkg::rot_im(K, N, FRAC));

    logic signed [AW-1:0] acc_re, acc_im;
    logic signed [AW-1:0] prod_re, prod_im;
    logic [CNTW-1:0]      cnt, pos;
    logic                 is_first, is_last, done_q;

    dft_cmul #(.AW(AW), .CW(CW), .FRAC(FRAC)) u_rot (
        .a_re (acc_re),
        .a_im (acc_im),
        .c_re (ROT_RE),
        .c_im (ROT_IM),
        .p_re (prod_re),
        .p_im (prod_im)
    );

    // Phase of the incoming sample: the frame marker forces phase zero.
    always_comb begin
        pos      = s_sof ? '0 : cnt;
        is_first = (pos == '0);
        is_last  = (pos == CNTW'(N - 1));
    end

    // Recursive accumulation and phase count on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re <= '0;
            acc_im <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= s_valid & is_last;
            if (s_valid) begin
                acc_re <= is_first ? AW'(s_re) : prod_re + AW'(s_re);
                acc_im <= is_first ? AW'(s_im) : prod_im + AW'(s_im);
                cnt    <= is_last ? '0 : pos + CNTW'(1);
            end
        end
    end

    // Present the final rotation for one cycle after a frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_re    <= '0;
            o_im    <= '0;
        end else begin
            o_valid <= done_q;
            o_re    <= done_q ? prod_re : '0;
            o_im    <= done_q ? prod_im : '0;
        end
    end

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |=> !o_valid);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> (o_re == '0 && o_im == '0));

    // R7
    sof_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_sof) |=> (cnt == CNTW'(1)));

    // R8
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < N);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> ($stable(cnt) && $stable(acc_re) && $stable(acc_im)));
endmodule

// File: rtl/goertzel_dft_array.sv
`timescale 1ns/1ps
// Module goertzel_dft_array
// Linear array of N bin cells fed by a sample chain that moves one cell
// per clock. Cell k therefore sees each frame k cycles after cell 0. The
// per-cell bins come out one per cycle and are merged onto a single
// output stream, tagged with the cell index.
// Assumes: N >= 2. Input magnitudes stay within the signed W-bit range.
module goertzel_dft_array #(
    parameter  int N    = 3,
    parameter  int W    = 16,
    parameter  int CW   = 16,
    localparam int AW   = W + $clog2(N) + 1,
    localparam int IDXW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic signed [W-1:0]  in_re,
    input  logic signed [W-1:0]  in_im,
    output logic                 bin_valid,
    output logic [IDXW-1:0]      bin_idx,
    output logic signed [AW-1:0] bin_re,
    output logic signed [AW-1:0] bin_im
);
    logic                 tap_valid [N];
    logic                 tap_sof   [N];
    logic signed [W-1:0]  tap_re    [N];
    logic signed [W-1:0]  tap_im    [N];

    logic [N-1:0]         cell_v;
    logic signed [AW-1:0] cell_re [N];
    logic signed [AW-1:0] cell_im [N];

    // Head of the chain is the input port itself.
    assign tap_valid[0] = in_valid;
    assign tap_sof[0]   = in_sof;
    assign tap_re[0]    = in_re;
    assign tap_im[0]    = in_im;

    for (genvar k = 1; k < N; k++) begin : g_chain
        dft_skew_stage #(.W(W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_valid (tap_valid[k-1]),
            .d_sof   (tap_sof[k-1]),
            .d_re    (tap_re[k-1]),
            .d_im    (tap_im[k-1]),
            .q_valid (tap_valid[k]),
            .q_sof   (tap_sof[k]),
            .q_re    (tap_re[k]),
            .q_im    (tap_im[k])
        );
    end

    for (genvar k = 0; k < N; k++) begin : g_cell
        dft_cell #(.N(N), .W(W), .CW(CW), .AW(AW), .K(k)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_valid (tap_valid[k]),
            .s_sof   (tap_sof[k]),
            .s_re    (tap_re[k]),
            .s_im    (tap_im[k]),
            .o_valid (cell_v[k]),
            .o_re    (cell_re[k]),
            .o_im    (cell_im[k])
        );
    end

    // Merge the cell results: at most one cell presents a bin per cycle.
    always_comb begin
        bin_valid = |cell_v;
        bin_idx   = '0;
        bin_re    = '0;
        bin_im    = '0;
        for (int k = 0; k < N; k++) begin
            if (cell_v[k]) begin
                bin_idx = IDXW'(k);
                bin_re  = cell_re[k];
                bin_im  = cell_im[k];
            end
        end
    end

    // R4
    one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cell_v));
endmodule

// File: tb/goertzel_dft_array_tb_top.sv
`timescale 1ns/1ps
module goertzel_dft_array_tb_top;
    localparam int  N      = 3;
    localparam int  W      = 16;
    localparam int  CW     = 16;
    localparam int  AW     = W + $clog2(N) + 1;
    localparam int  IDXW   = $clog2(N);
    localparam real TOL    = 8.0;
    localparam real TWO_PI = 6.283185307179586;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_sof = 1'b0;
    logic signed [W-1:0]  in_re = '0;
    logic signed [W-1:0]  in_im = '0;
    logic                 bin_valid;
    logic [IDXW-1:0]      bin_idx;
    logic signed [AW-1:0] bin_re, bin_im;

    int    checks = 0;
    int    failures = 0;
    int    edge_n = 0;
    int    mcnt = 0;
    int    fr_re [N];
    int    fr_im [N];
    bit    ex_v  [64];
    int    ex_t  [64];
    int    ex_k  [64];
    real   ex_re [64];
    real   ex_im [64];
    string tag = "R8";

    always #4 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    goertzel_dft_array #(.N(N), .W(W), .CW(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_re     (in_re),
        .in_im     (in_im),
        .bin_valid (bin_valid),
        .bin_idx   (bin_idx),
        .bin_re    (bin_re),
        .bin_im    (bin_im)
    );

    function automatic real rabs(real v);
        return (v < 0.0) ? -v : v;
    endfunction

    function automatic int rnd13();
        return int'($urandom_range(16382)) - 8191;
    endfunction

    task automatic chk(input bit ok, input string what, input real act, input real expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0.2f expected=%0.2f at t=%0t", what, act, expv, $time);
        end
    endtask

    // Reference model: collects frames and schedules the exact DFT bins.
    task automatic model_push(input bit v, input bit s, input int re, input int im, input int e);
        int pos;
        if (!v) return;                          // R6: idle cycles ignored
        pos = s ? 0 : mcnt;                      // R7 / R8 framing
        fr_re[pos] = re;
        fr_im[pos] = im;
        if (pos == N - 1) begin
            for (int k = 0; k < N; k++) begin
                real sr = 0.0;
                real si = 0.0;
                int  sl = (e + k + 1) % 64;      // R3 latency
                for (int n = 0; n < N; n++) begin
                    real th = TWO_PI * real'(k * n) / real'(N);
                    sr += real'(fr_re[n]) * $cos(th) + real'(fr_im[n]) * $sin(th);
                    si += real'(fr_im[n]) * $cos(th) - real'(fr_re[n]) * $sin(th);
                end
                ex_v[sl]  = 1'b1;
                ex_t[sl]  = e + k + 1;
                ex_k[sl]  = k;
                ex_re[sl] = sr;
                ex_im[sl] = si;
            end
            mcnt = 0;
        end else begin
            mcnt = pos + 1;
        end
    endtask

    // Compare the output stream against the schedule for this cycle.
    task automatic check_out();
        int sl;
        bit want;
        sl   = edge_n % 64;
        want = ex_v[sl] && (ex_t[sl] == edge_n);
        if (bin_valid) begin
            chk(want, "R3 bin_valid with no bin due", 1.0, 0.0);
            if (want) begin
                chk(int'(bin_idx) == ex_k[sl], "R4 bin_idx", real'(bin_idx), real'(ex_k[sl]));
                chk(rabs(real'(bin_re) - ex_re[sl]) <= TOL, {"R2 real part, ", tag}, real'(bin_re), ex_re[sl]);
                chk(rabs(real'(bin_im) - ex_im[sl]) <= TOL, {"R2 imag part, ", tag}, real'(bin_im), ex_im[sl]);
            end
        end else begin
            chk(!want, {"R3 missing bin, ", tag}, 0.0, 1.0);
            chk(bin_re == '0 && bin_im == '0 && bin_idx == '0, "R9 idle outputs nonzero",
                real'(bin_re), 0.0);
        end
        if (want) ex_v[sl] = 1'b0;
    endtask

    task automatic step(input bit v, input bit s, input int re, input int im);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_sof   = s;
        in_re    = W'(re);
        in_im    = W'(im);
        model_push(v, s, re, im, edge_n + 1);
    endtask

    initial begin
        int pend;
        // R1: quiet outputs during reset and right after release
        repeat (4) begin
            @(negedge clk);
            chk(!bin_valid && bin_re == '0 && bin_im == '0, "R1 output during reset", real'(bin_valid), 0.0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bin_valid, "R1 output after reset release", real'(bin_valid), 0.0);

        // R8: first frame framed by counting only (impulse)
        tag = "R8 impulse, no marker";
        step(1'b1, 1'b0, 1000, 0);
        step(1'b1, 1'b0, 0, 0);
        step(1'b1, 1'b0, 0, 0);

        // R2: constant input frame
        tag = "R2 dc";
        for (int n = 0; n < N; n++) step(1'b1, n == 0, 20000, -20000);

        // R2: full-scale impulse at sample 1
        tag = "R2 delayed impulse";
        step(1'b1, 1'b1, 0, 0);
        step(1'b1, 1'b0, 32767, -32768);
        step(1'b1, 1'b0, 0, 0);

        // R5: back-to-back random frames
        tag = "R5 back-to-back";
        for (int f = 0; f < 20; f++)
            for (int n = 0; n < N; n++) step(1'b1, n == 0, rnd13(), rnd13());

        // R6: idle gaps with junk data and stray markers
        tag = "R6 gaps";
        for (int f = 0; f < 10; f++)
            for (int n = 0; n < N; n++) begin
                int gaps = int'($urandom_range(2));
                for (int g = 0; g < gaps; g++) step(1'b0, 1'b1, rnd13(), rnd13());
                step(1'b1, n == 0, rnd13(), rnd13());
            end

        // R7: partial frame aborted by a new frame marker
        tag = "R7 abort";
        step(1'b1, 1'b1, 5000, 5000);
        step(1'b1, 1'b0, -7000, 3000);
        for (int n = 0; n < N; n++) step(1'b1, n == 0, rnd13(), rnd13());

        // R8: frames delimited by count after a marked frame
        tag = "R8 counted";
        for (int f = 0; f < 4; f++)
            for (int n = 0; n < N; n++) step(1'b1, 1'b0, rnd13(), rnd13());

        // Drain
        tag = "drain";
        repeat (N + 3) step(1'b0, 1'b0, 0, 0);
        pend = 0;
        for (int i = 0; i < 64; i++) if (ex_v[i]) pend++;
        chk(pend == 0, "R3 bins never produced", real'(pend), 0.0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0.0, 0.0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule